// File: doc/BRIEF.md
# Ticketed Job Slot Flow Controller

This block hands out ordered positions in a circular job queue that many initiators share when they all feed one destination. An initiator raises its request line and, if room remains, receives in the same cycle a ticket drawn from a single issue count (an atomic fetch-and-add), plus the queue slot that ticket maps to. It writes its job into that slot. The ticket also serves as its completion handle.

A server at the destination pops jobs in ticket order and advances a done count. An initiator that asked for a blocking request waits until the done count reaches its ticket. A posted request is released as soon as its slot is granted. When several initiators ask in the same cycle, tickets are handed out in a rotating, round-robin order of port index. The rotation resumes at the port after the last one served, so service from the queue is fair across initiators.

Both counters wrap modulo 2^CNT_W. Every compare takes the difference of two counters, so wraparound does no harm.

Top module: `ticket_slot_ctrl`

## Requirements
- R1: After reset, both the issue and the done count are zero, no port is waiting or completing, and the queue reports empty.
- R2: A granted request receives ticket = (issue count before the grant) + 1. Requests granted in one cycle receive consecutive tickets, and the issue count advances by the number of grants.
- R3: A request whose candidate ticket T satisfies (T − done) mod 2^CNT_W ≥ QDEPTH is refused, so at most QDEPTH−1 jobs are outstanding. Every later request in the same cycle is refused too.
- R4: The slot returned with a grant is the ticket modulo QDEPTH, which is its low log2(QDEPTH) bits.
- R5: In a cycle with several requests, candidates are taken in the order ptr, ptr+1, … (mod NPORT). After any grant, ptr moves to the port after the last granted port. Out of reset, ptr is 0.
- R6: A blocking grant (posted_i low) sets the port's busy flag from the next cycle. cpl_o pulses for that port in the cycle where (done − ticket), read as a signed CNT_W-bit value, is ≥ 0. busy clears in the cycle after.
- R7: A posted grant (posted_i high) leaves the port not busy and produces no completion pulse.
- R8: A request from a busy port is ignored. It gets no grant, takes no ticket and does not move ptr.
- R9: head_vld_o is high when done ≠ issue, and head_slot_o = (done+1) mod QDEPTH. pop_i with the queue non-empty adds one to done. pop_i on an empty queue leaves done unchanged.
- R10: Both counters wrap modulo 2^CNT_W. Backpressure, completion and slot results stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_i | input | NPORT | Slot request, one bit per initiator |
| posted_i | input | NPORT | 1 = posted request, 0 = blocking request |
| gnt_o | output | NPORT | Slot granted this cycle |
| tkt_o | output | NPORT*CNT_W | Ticket per port, valid with gnt_o; port i occupies bits [i*CNT_W +: CNT_W] |
| slot_o | output | NPORT*log2(QDEPTH) | Queue slot per port, valid with gnt_o |
| busy_o | output | NPORT | Port is waiting on a blocking ticket |
| cpl_o | output | NPORT | Waiting ticket has completed (one-cycle pulse) |
| pop_i | input | 1 | Server removes the head job |
| head_vld_o | output | 1 | Queue holds at least one job |
| head_slot_o | output | log2(QDEPTH) | Slot of the oldest job |
| done_o | output | CNT_W | Done count |

## Verification
First, a single posted request checks the basic ticket-to-slot mapping. Next, all ports request in one cycle: this shows the rotating order, the run of consecutive tickets, and the point where backpressure cuts the run off. A blocking request followed by a repeated request from the same port separates a completed ticket from one that is still waiting, and shows that a busy port's request is dropped. Pops on an empty queue show that done stays put. A long run of mixed random requests and pops is made with a narrow counter. It wraps both counts several times and shows whether the compares treat the wrap as ordinary arithmetic.

// File: rtl/tfc_pkg.sv
// Shared helpers for the ticketed slot controller.
// Assumes: callers pass positive sizes.
package tfc_pkg;
    // Bit width needed to index v items, never less than one.
    function automatic int idx_width(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction
endpackage

// File: rtl/tfc_alloc.sv
// Ticket allocator: walks the ports in rotating order from ptr_i and grants
// consecutive tickets while the queue still has room against done_i.
// Assumes: req_i is already masked with busy ports removed.
module tfc_alloc #(
    parameter int NPORT = 4,
    parameter int CNT_W = 32,
    parameter int QDEPTH = 16,
    localparam int PW = tfc_pkg::idx_width(NPORT)
) (
    input  logic [NPORT-1:0] req_i,
    input  logic [PW-1:0]    ptr_i,
    input  logic [CNT_W-1:0] issue_i,
    input  logic [CNT_W-1:0] done_i,
    output logic [NPORT-1:0] gnt_o,
    output logic [CNT_W-1:0] tkt_o [NPORT],
    output logic [CNT_W-1:0] issue_nxt_o,
    output logic             any_o,
    output logic [PW-1:0]    last_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(QDEPTH);

    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] cand;
    logic             blocked;
    int               idx;

    // Rotating scan that hands out tickets until the first refusal.
    always_comb begin
        nxt     = issue_i;
        blocked = 1'b0;
        gnt_o   = '0;
        any_o   = 1'b0;
        last_o  = ptr_i;
        cand    = '0;
        idx     = 0;
        for (int i = 0; i < NPORT; i++) tkt_o[i] = '0;
        for (int k = 0; k < NPORT; k++) begin
            idx = int'(ptr_i) + k;
            if (idx >= NPORT) idx = idx - NPORT;
            cand = nxt + CNT_W'(1);
            if (req_i[idx] && !blocked) begin
                if ((cand - done_i) < DEPTH_C) begin
                    gnt_o[idx] = 1'b1;
                    tkt_o[idx] = cand;
                    nxt        = cand;
                    any_o      = 1'b1;
                    last_o     = PW'(idx);
                end else begin
                    blocked = 1'b1;
                end
            end
        end
        issue_nxt_o = nxt;
    end
endmodule

// File: rtl/tfc_rr_ptr.sv
// Round-robin start pointer: moves to the port after the last granted one.
// Assumes: last_i < NPORT whenever adv_i is high.
module tfc_rr_ptr #(
    parameter int NPORT = 4,
    localparam int PW = tfc_pkg::idx_width(NPORT)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          adv_i,
    input  logic [PW-1:0] last_i,
    output logic [PW-1:0] ptr_o
);
    // Pointer register, wrapping at NPORT.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ptr_o <= '0;
        end else if (adv_i) begin
            ptr_o <= (int'(last_i) == NPORT - 1) ? '0 : last_i + PW'(1);
        end
    end
endmodule

// File: rtl/tfc_waiter.sv
// Per-port completion tracker for blocking requests.
// Assumes: grant_i is never high while busy_o is high.
module tfc_waiter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             grant_i,
    input  logic             posted_i,
    input  logic [CNT_W-1:0] tkt_i,
    input  logic [CNT_W-1:0] done_i,
    output logic             busy_o,
    output logic             cpl_o
);
    logic [CNT_W-1:0] wtkt_q;
    logic [CNT_W-1:0] diff;

    // Hold the ticket while waiting; release after the completion pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy_o <= 1'b0;
            wtkt_q <= '0;
        end else if (grant_i && !posted_i) begin
            busy_o <= 1'b1;
            wtkt_q <= tkt_i;
        end else if (cpl_o) begin
            busy_o <= 1'b0;
        end
    end

    // Wrap-safe "done has reached ticket" test.
    always_comb begin
        diff  = done_i - wtkt_q;
        cpl_o = busy_o & ~diff[CNT_W-1];
    end
endmodule

// File: rtl/ticket_slot_ctrl.sv
// Ticketed job slot flow controller: issue and done counters, grant logic,
// slot mapping and per-port completion waiters.
// Assumes: QDEPTH is a power of two, at least 2 and below 2^(CNT_W-1).
module ticket_slot_ctrl #(
    parameter int NPORT = 4,
    parameter int CNT_W = 32,
    parameter int QDEPTH = 16,
    localparam int SW = $clog2(QDEPTH),
    localparam int PW = tfc_pkg::idx_width(NPORT)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NPORT-1:0]       req_i,
    input  logic [NPORT-1:0]       posted_i,
    output logic [NPORT-1:0]       gnt_o,
    output logic [NPORT*CNT_W-1:0] tkt_o,
    output logic [NPORT*SW-1:0]    slot_o,
    output logic [NPORT-1:0]       busy_o,
    output logic [NPORT-1:0]       cpl_o,
    input  logic                   pop_i,
    output logic                   head_vld_o,
    output logic [SW-1:0]          head_slot_o,
    output logic [CNT_W-1:0]       done_o
);
    logic [CNT_W-1:0] issue_q;
    logic [CNT_W-1:0] done_q;
    logic [CNT_W-1:0] issue_nxt;
    logic [CNT_W-1:0] tkt_a [NPORT];
    logic [NPORT-1:0] req_eff;
    logic [PW-1:0]    ptr;
    logic [PW-1:0]    last;
    logic             any_gnt;
    logic [CNT_W-1:0] head_tkt;

    assign req_eff    = req_i & ~busy_o;
    assign head_vld_o = (done_q != issue_q);
    assign head_tkt   = done_q + CNT_W'(1);
    assign head_slot_o = head_tkt[SW-1:0];
    assign done_o     = done_q;

    tfc_alloc #(.NPORT(NPORT), .CNT_W(CNT_W), .QDEPTH(QDEPTH)) u_alloc (
        .req_i      (req_eff),
        .ptr_i      (ptr),
        .issue_i    (issue_q),
        .done_i     (done_q),
        .gnt_o      (gnt_o),
        .tkt_o      (tkt_a),
        .issue_nxt_o(issue_nxt),
        .any_o      (any_gnt),
        .last_o     (last)
    );

    tfc_rr_ptr #(.NPORT(NPORT)) u_ptr (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .adv_i (any_gnt),
        .last_i(last),
        .ptr_o (ptr)
    );

    // Issue and done counters.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            issue_q <= '0;
            done_q  <= '0;
        end else begin
            issue_q <= issue_nxt;
            if (pop_i && head_vld_o) done_q <= head_tkt;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign tkt_o[g*CNT_W +: CNT_W] = tkt_a[g];
        assign slot_o[g*SW +: SW]      = tkt_a[g][SW-1:0];

        tfc_waiter #(.CNT_W(CNT_W)) u_wait (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .grant_i (gnt_o[g]),
            .posted_i(posted_i[g]),
            .tkt_i   (tkt_a[g]),
            .done_i  (done_q),
            .busy_o  (busy_o[g]),
            .cpl_o   (cpl_o[g])
        );
    end
endmodule

// File: rtl/tfc_checker.sv
// Temporal checks for ticket_slot_ctrl, attached by bind.
// Assumes: same parameters as the bound instance.
module tfc_checker #(
    parameter int NPORT = 4,
    parameter int CNT_W = 32,
    parameter int QDEPTH = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [NPORT-1:0] gnt,
    input logic [NPORT-1:0] posted,
    input logic [NPORT-1:0] busy,
    input logic [NPORT-1:0] cpl,
    input logic             pop,
    input logic             head_vld,
    input logic [CNT_W-1:0] issue,
    input logic [CNT_W-1:0] done
);
    p_outstanding_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue - done) < CNT_W'(QDEPTH));

    p_issue_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> issue == $past(issue) + CNT_W'($countones($past(gnt))));

    p_empty_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop && !head_vld) |=> $stable(done));

    p_done_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop && head_vld) |=> done == $past(done) + CNT_W'(1));

    for (genvar g = 0; g < NPORT; g++) begin : g_chk
        p_busy_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            busy[g] |-> !gnt[g]);
        p_block_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt[g] && !posted[g]) |=> busy[g]);
        p_cpl_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cpl[g] |=> !busy[g]);
        p_posted_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt[g] && posted[g]) |=> !busy[g]);
    end
endmodule

bind ticket_slot_ctrl tfc_checker #(.NPORT(NPORT), .CNT_W(CNT_W), .QDEPTH(QDEPTH)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gnt     (gnt_o),
    .posted  (posted_i),
    .busy    (busy_o),
    .cpl     (cpl_o),
    .pop     (pop_i),
    .head_vld(head_vld_o),
    .issue   (issue_q),
    .done    (done_q)
);

// File: tb/sim_ticket_slot_ctrl.sv
`timescale 1ns/1ps
module sim_ticket_slot_ctrl;
    localparam int N  = 3;
    localparam int CW = 8;
    localparam int D  = 4;
    localparam int SW = 2;

    typedef struct {
        int           port;
        logic [CW-1:0] tkt;
        logic [SW-1:0] slot;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    pst = '0;
    logic            pop = 1'b0;
    logic [N-1:0]    gnt, busy, cpl;
    logic [N*CW-1:0] tkt;
    logic [N*SW-1:0] slot;
    logic            hvld;
    logic [SW-1:0]   hslot;
    logic [CW-1:0]   done;

    ticket_slot_ctrl #(.NPORT(N), .CNT_W(CW), .QDEPTH(D)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .posted_i(pst),
        .gnt_o(gnt), .tkt_o(tkt), .slot_o(slot), .busy_o(busy), .cpl_o(cpl),
        .pop_i(pop), .head_vld_o(hvld), .head_slot_o(hslot), .done_o(done)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit armed = 0;
    bit ended = 0;

    // Reference model state.
    logic [CW-1:0] m_issue = '0, m_done = '0;
    int            m_ptr = 0;
    logic [N-1:0]  m_busy = '0;
    logic [CW-1:0] m_wtkt [N];
    exp_t          sbq[$];
    logic [N-1:0]  e_gnt, e_cpl, e_busy;
    logic          e_hvld;
    logic [SW-1:0] e_hslot;
    logic [CW-1:0] e_done;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: apply one cycle of stimulus and push its expected results.
    task automatic step(input logic [N-1:0] rq, input logic [N-1:0] ps, input logic pp);
        logic [CW-1:0] nxt, t;
        bit stop, any;
        int last;
        @(negedge clk);
        req = rq; pst = ps; pop = pp;
        e_busy = m_busy;
        e_done = m_done;
        e_hvld = (m_done != m_issue);
        t = m_done + CW'(1);
        e_hslot = t[SW-1:0];
        for (int i = 0; i < N; i++) begin
            t = m_done - m_wtkt[i];
            e_cpl[i] = m_busy[i] && !t[CW-1];
        end
        e_gnt = '0; nxt = m_issue; stop = 0; any = 0; last = 0;
        for (int k = 0; k < N; k++) begin
            int p;
            p = (m_ptr + k) % N;
            if (rq[p] && !m_busy[p] && !stop) begin
                t = nxt + CW'(1);
                if (CW'(t - m_done) < CW'(D)) begin
                    exp_t it;
                    e_gnt[p] = 1'b1;
                    it.port = p; it.tkt = t; it.slot = t[SW-1:0];
                    sbq.push_back(it);
                    nxt = t; any = 1; last = p;
                    if (!ps[p]) begin m_busy[p] = 1'b1; m_wtkt[p] = t; end
                end else stop = 1;
            end
        end
        for (int i = 0; i < N; i++) if (e_cpl[i]) m_busy[i] = 1'b0;
        if (pp && e_hvld) m_done = m_done + CW'(1);
        m_issue = nxt;
        if (any) m_ptr = (last + 1) % N;
    endtask

    // Monitor: compare outputs against the scoreboard away from the edge.
    always @(negedge clk) begin
        if (armed) begin
            #2;
            check("R3 R5 R8 grant mask", 32'(gnt), 32'(e_gnt));
            while (sbq.size() > 0) begin
                exp_t it;
                it = sbq.pop_front();
                check("R2 R10 ticket", 32'(tkt[it.port*CW +: CW]), 32'(it.tkt));
                check("R4 slot", 32'(slot[it.port*SW +: SW]), 32'(it.slot));
            end
            check("R6 R7 completion", 32'(cpl), 32'(e_cpl));
            check("R6 R7 R8 busy", 32'(busy), 32'(e_busy));
            check("R9 head valid", 32'(hvld), 32'(e_hvld));
            if (e_hvld) check("R9 head slot", 32'(hslot), 32'(e_hslot));
            check("R9 R10 done count", 32'(done), 32'(e_done));
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 50000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) m_wtkt[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check("R1 done after reset", 32'(done), 0);
        check("R1 empty after reset", 32'(hvld), 0);
        check("R1 busy after reset", 32'(busy), 0);
        check("R1 cpl after reset", 32'(cpl), 0);
        armed = 1;
        step(3'b001, 3'b001, 1'b0);   // R2 R4: first ticket 1, slot 1
        step(3'b111, 3'b111, 1'b0);   // R5 from port 1; R3 cuts port 0
        step(3'b111, 3'b111, 1'b0);   // R3: queue full, nothing granted
        step(3'b000, 3'b000, 1'b1);   // R9 pop
        step(3'b100, 3'b000, 1'b0);   // R6 blocking port 2
        step(3'b000, 3'b000, 1'b1);
        step(3'b000, 3'b000, 1'b1);
        step(3'b100, 3'b100, 1'b0);   // R8: busy port 2 ignored
        step(3'b000, 3'b000, 1'b1);   // done reaches ticket
        step(3'b000, 3'b000, 1'b0);   // R6 completion pulse
        step(3'b000, 3'b000, 1'b0);
        repeat (4) step(3'b000, 3'b000, 1'b1);  // R9 pops on empty queue
        for (int c = 0; c < 1500; c++)          // R10: several counter wraps
            step(3'($urandom), 3'($urandom), 1'($urandom));
        repeat (12) step(3'b000, 3'b000, 1'b1);
        @(negedge clk);
        #3;
        armed = 0;
        finish_run();
    end
endmodule